// File: doc/BRIEF.md
# Dual-Port Command/Data Mailbox

This block carries short messages between a group of application cores (side A) and a microcontroller (side B). Each direction has its own bank of registers: one command word and one data word per channel, a pending-status register and an interrupt-enable register. A sender writes the command word and then the data word of a channel. The data write marks that channel pending in the status register of its direction. If the receiver has enabled that channel, a dedicated interrupt line toward the receiver is raised.

The receiver reads the command and data words of the channel. It then writes a one to the channel's status bit, which drops the pending flag and the interrupt. Each side has a simple register port of its own: a write strobe, a byte address, write data and combinational read data. Both sides can read every register. Each side can write only the registers it owns, as listed in R7.

Top module: `mbox_dual`

## Requirements
- R1: After reset, every register reads as zero and all interrupt outputs are low.
- R2: Side A writes the command word of channel i at byte address 0x08+8i and the data word at 0x0C+8i. Both ports read back the stored values at those addresses.
- R3: A side-A write to the data address of channel i sets bit i of the A-to-B status register (address 0x04) from the next clock. A write to the command address alone leaves that bit unchanged.
- R4: Side B writes the A-to-B enable register at 0x00, and only its low CH bits are kept. `irq_to_b[i]` is high exactly when A-to-B status bit i and enable bit i are both set.
- R5: A side-B write to 0x04 clears each A-to-B status bit whose write-data bit is 1. Bits written as 0 are left unchanged.
- R6: The B-to-A direction mirrors R2 to R5 with the roles of the sides swapped. Side B writes command words at 0x30+8i and data words at 0x34+8i, which set B-to-A status bits (at 0x2C). Side A writes the B-to-A enable register at 0x28 and clears the status at 0x2C with a write of one. `irq_to_a[i]` is the AND of B-to-A status bit i and enable bit i.
- R7: Side A writes have no effect at 0x00, 0x04 or the B-to-A command and data addresses. Side B writes have no effect at 0x28, 0x2C or the A-to-B command and data addresses.
- R8: If a data write and a clear of the same channel's status bit happen in the same clock, the bit stays set.
- R9: A read of an address that holds no register returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_wr | input | 1 | Side A write strobe |
| a_addr | input | AW | Side A byte address |
| a_wdata | input | DW | Side A write data |
| a_rdata | output | DW | Side A read data (combinational) |
| b_wr | input | 1 | Side B write strobe |
| b_addr | input | AW | Side B byte address |
| b_wdata | input | DW | Side B write data |
| b_rdata | output | DW | Side B read data (combinational) |
| irq_to_a | output | CH | Per-channel interrupts toward side A |
| irq_to_b | output | CH | Per-channel interrupts toward side B |

## Verification
The sender's data write (which sets a status bit) and the receiver's write-one-to-clear (which drops it) can land on the same status bit in the same clock. The bench drives both ports in one cycle: a data write to channel 1 from one side and a clear of bit 1 from the other. It expects the bit to read back set, and it does this in both directions. A second case pairs a clear of one channel with a set of another in the same cycle, and checks that each bit follows its own request.

// File: rtl/mbox_dual.sv
module mbox_dual #(
  parameter int CH = 4,
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_wr,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_wr,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic [CH-1:0] irq_to_a,
  output logic [CH-1:0] irq_to_b
);

  localparam int AB_EN  = 0;
  localparam int AB_ST  = 4;
  localparam int AB_CH0 = 8;
  localparam int BA_EN  = AB_CH0 + 8 * CH;
  localparam int BA_ST  = BA_EN + 4;
  localparam int BA_CH0 = BA_EN + 8;

  logic [CH-1:0] ab_en, ab_st, ba_en, ba_st;
  logic [DW-1:0] ab_cmd [CH];
  logic [DW-1:0] ab_dat [CH];
  logic [DW-1:0] ba_cmd [CH];
  logic [DW-1:0] ba_dat [CH];

  logic [CH-1:0] ab_set, ab_clr, ba_set, ba_clr;

  always_comb begin
    for (int i = 0; i < CH; i++) begin
      ab_set[i] = a_wr && (a_addr == AW'(AB_CH0 + 8 * i + 4));
      ba_set[i] = b_wr && (b_addr == AW'(BA_CH0 + 8 * i + 4));
    end
  end

  assign ab_clr = (b_wr && b_addr == AW'(AB_ST)) ? b_wdata[CH-1:0] : '0;
  assign ba_clr = (a_wr && a_addr == AW'(BA_ST)) ? a_wdata[CH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ab_en <= '0;
      ba_en <= '0;
      ab_st <= '0;
      ba_st <= '0;
      for (int i = 0; i < CH; i++) begin
        ab_cmd[i] <= '0;
        ab_dat[i] <= '0;
        ba_cmd[i] <= '0;
        ba_dat[i] <= '0;
      end
    end else begin
      if (b_wr && b_addr == AW'(AB_EN)) ab_en <= b_wdata[CH-1:0];
      if (a_wr && a_addr == AW'(BA_EN)) ba_en <= a_wdata[CH-1:0];
      ab_st <= ab_set | (ab_st & ~ab_clr);
      ba_st <= ba_set | (ba_st & ~ba_clr);
      for (int i = 0; i < CH; i++) begin
        if (a_wr && a_addr == AW'(AB_CH0 + 8 * i)) ab_cmd[i] <= a_wdata;
        if (ab_set[i])                             ab_dat[i] <= a_wdata;
        if (b_wr && b_addr == AW'(BA_CH0 + 8 * i)) ba_cmd[i] <= b_wdata;
        if (ba_set[i])                             ba_dat[i] <= b_wdata;
      end
    end
  end

  assign irq_to_b = ab_st & ab_en;
  assign irq_to_a = ba_st & ba_en;

  always_comb begin
    a_rdata = '0;
    if (a_addr == AW'(AB_EN)) a_rdata = DW'(ab_en);
    if (a_addr == AW'(AB_ST)) a_rdata = DW'(ab_st);
    if (a_addr == AW'(BA_EN)) a_rdata = DW'(ba_en);
    if (a_addr == AW'(BA_ST)) a_rdata = DW'(ba_st);
    for (int i = 0; i < CH; i++) begin
      if (a_addr == AW'(AB_CH0 + 8 * i))     a_rdata = ab_cmd[i];
      if (a_addr == AW'(AB_CH0 + 8 * i + 4)) a_rdata = ab_dat[i];
      if (a_addr == AW'(BA_CH0 + 8 * i))     a_rdata = ba_cmd[i];
      if (a_addr == AW'(BA_CH0 + 8 * i + 4)) a_rdata = ba_dat[i];
    end
  end

  always_comb begin
    b_rdata = '0;
    if (b_addr == AW'(AB_EN)) b_rdata = DW'(ab_en);
    if (b_addr == AW'(AB_ST)) b_rdata = DW'(ab_st);
    if (b_addr == AW'(BA_EN)) b_rdata = DW'(ba_en);
    if (b_addr == AW'(BA_ST)) b_rdata = DW'(ba_st);
    for (int i = 0; i < CH; i++) begin
      if (b_addr == AW'(AB_CH0 + 8 * i))     b_rdata = ab_cmd[i];
      if (b_addr == AW'(AB_CH0 + 8 * i + 4)) b_rdata = ab_dat[i];
      if (b_addr == AW'(BA_CH0 + 8 * i))     b_rdata = ba_cmd[i];
      if (b_addr == AW'(BA_CH0 + 8 * i + 4)) b_rdata = ba_dat[i];
    end
  end

  for (genvar g = 0; g < CH; g++) begin : g_chk
    a_r3_ab_data_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (a_wr && a_addr == AW'(AB_CH0 + 8 * g + 4)) |=> ab_st[g]);
    a_r6_ba_data_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (b_wr && b_addr == AW'(BA_CH0 + 8 * g + 4)) |=> ba_st[g]);
    a_r5_ab_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (b_wr && b_addr == AW'(AB_ST) && b_wdata[g] &&
       !(a_wr && a_addr == AW'(AB_CH0 + 8 * g + 4))) |=> !irq_to_b[g]);
    a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
      (!ab_st[g] && !(a_wr && a_addr == AW'(AB_CH0 + 8 * g + 4))) |=> !ab_st[g]);
  end

  a_r7_ab_en_owner: assert property (@(posedge clk) disable iff (!rst_n)
    !(b_wr && b_addr == AW'(AB_EN)) |=> $stable(ab_en));
  a_r7_ba_en_owner: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_wr && a_addr == AW'(BA_EN)) |=> $stable(ba_en));

endmodule

// File: tb/sim_mbox_dual.sv
module sim_mbox_dual;
  localparam int CLK_NS = 10;
  localparam int CH = 4, DW = 32, AW = 8;

  logic clk = 0, rst_n = 0;
  logic a_wr = 0, b_wr = 0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic [DW-1:0] a_rdata, b_rdata;
  logic [CH-1:0] irq_to_a, irq_to_b;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_NS / 2) clk = ~clk;

  mbox_dual #(.CH(CH), .DW(DW), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .irq_to_a(irq_to_a), .irq_to_b(irq_to_b));

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr2(input bit wa, input logic [AW-1:0] aa, input logic [DW-1:0] ad,
                     input bit wb, input logic [AW-1:0] ba, input logic [DW-1:0] bd);
    a_wr = wa; a_addr = aa; a_wdata = ad;
    b_wr = wb; b_addr = ba; b_wdata = bd;
    @(posedge clk);
    @(negedge clk);
    a_wr = 0; b_wr = 0;
  endtask

  task automatic wra(input logic [AW-1:0] ad, input logic [DW-1:0] d);
    wr2(1, ad, d, 0, '0, '0);
  endtask

  task automatic wrb(input logic [AW-1:0] ad, input logic [DW-1:0] d);
    wr2(0, '0, '0, 1, ad, d);
  endtask

  task automatic rda(input logic [AW-1:0] ad, output logic [DW-1:0] d);
    a_addr = ad; #1; d = a_rdata;
  endtask

  task automatic rdb(input logic [AW-1:0] ad, output logic [DW-1:0] d);
    b_addr = ad; #1; d = b_rdata;
  endtask

  task automatic t_reset;
    logic [DW-1:0] d;
    for (int ad = 0; ad < 8'h50; ad += 4) begin
      rda(AW'(ad), d);
      check("R1 reg zero", d, '0);
    end
    check("R1 irq_to_a", DW'(irq_to_a), '0);
    check("R1 irq_to_b", DW'(irq_to_b), '0);
  endtask

  task automatic t_a2b;
    logic [DW-1:0] d;
    wra(8'h18, 32'h1111_2222);
    rdb(8'h04, d); check("R3 cmd alone no status", d, 32'h0);
    wra(8'h1C, 32'h3333_4444);
    rdb(8'h04, d); check("R3 data sets status", d, 32'h4);
    check("R4 irq masked", DW'(irq_to_b), 32'h0);
    rdb(8'h18, d); check("R2 cmd readback B", d, 32'h1111_2222);
    rdb(8'h1C, d); check("R2 data readback B", d, 32'h3333_4444);
    rda(8'h1C, d); check("R2 data readback A", d, 32'h3333_4444);
    wrb(8'h00, 32'hFFFF_FFFF);
    rdb(8'h00, d); check("R4 enable width", d, 32'hF);
    check("R4 irq_to_b", DW'(irq_to_b), 32'h4);
    check("R6 irq_to_a quiet", DW'(irq_to_a), 32'h0);
  endtask

  task automatic t_w1c;
    logic [DW-1:0] d;
    wra(8'h0C, 32'hA5A5_0000);
    rdb(8'h04, d); check("R3 two pending", d, 32'h5);
    check("R4 two irqs", DW'(irq_to_b), 32'h5);
    wrb(8'h04, 32'h4);
    rdb(8'h04, d); check("R5 clear one", d, 32'h1);
    check("R5 irq after clear", DW'(irq_to_b), 32'h1);
    wrb(8'h04, 32'h1);
    rdb(8'h04, d); check("R5 clear last", d, 32'h0);
    rdb(8'h0C, d); check("R5 data kept", d, 32'hA5A5_0000);
  endtask

  task automatic t_b2a;
    logic [DW-1:0] d;
    wrb(8'h48, 32'hCAFE_0003);
    rda(8'h2C, d); check("R6 cmd alone no status", d, 32'h0);
    wrb(8'h4C, 32'hBEEF_0003);
    rda(8'h2C, d); check("R6 status set", d, 32'h8);
    check("R6 irq masked", DW'(irq_to_a), 32'h0);
    wra(8'h28, 32'h8);
    check("R6 irq_to_a", DW'(irq_to_a), 32'h8);
    rda(8'h48, d); check("R6 cmd readback", d, 32'hCAFE_0003);
    rda(8'h4C, d); check("R6 data readback", d, 32'hBEEF_0003);
    wra(8'h2C, 32'h8);
    rda(8'h2C, d); check("R6 clear", d, 32'h0);
    check("R6 irq cleared", DW'(irq_to_a), 32'h0);
  endtask

  task automatic t_owner;
    logic [DW-1:0] d;
    wrb(8'h00, 32'h0);
    wra(8'h00, 32'hF);
    rda(8'h00, d); check("R7 A cannot enable A2B", d, 32'h0);
    wra(8'h30, 32'h1234);
    rda(8'h30, d); check("R7 A cannot write B2A cmd", d, 32'h0);
    wra(8'h34, 32'h5678);
    rda(8'h2C, d); check("R7 A cannot post B2A", d, 32'h0);
    wrb(8'h08, 32'h9999);
    rdb(8'h08, d); check("R7 B cannot write A2B cmd", d, 32'h0);
    wrb(8'h28, 32'hF);
    rdb(8'h28, d); check("R7 B cannot enable B2A", d, 32'h8);
    wra(8'h0C, 32'h1);
    wra(8'h04, 32'hF);
    rda(8'h04, d); check("R7 A cannot clear A2B", d, 32'h1);
    wrb(8'h34, 32'h2);
    wrb(8'h2C, 32'hF);
    rdb(8'h2C, d); check("R7 B cannot clear B2A", d, 32'h1);
    wrb(8'h04, 32'h1);
    wra(8'h2C, 32'h1);
  endtask

  task automatic t_collide;
    logic [DW-1:0] d;
    wra(8'h14, 32'h1);
    wr2(1, 8'h14, 32'h2, 1, 8'h04, 32'h2);
    rdb(8'h04, d); check("R8 A2B set beats clear", d, 32'h2);
    rdb(8'h14, d); check("R8 A2B new data", d, 32'h2);
    wr2(1, 8'h1C, 32'h7, 1, 8'h04, 32'h2);
    rdb(8'h04, d); check("R8 clear one set other", d, 32'h4);
    wrb(8'h3C, 32'h1);
    wr2(1, 8'h2C, 32'h2, 1, 8'h3C, 32'h3);
    rda(8'h2C, d); check("R8 B2A set beats clear", d, 32'h2);
  endtask

  task automatic t_unmapped;
    logic [DW-1:0] d;
    rda(8'h50, d); check("R9 past map", d, 32'h0);
    rdb(8'hFC, d); check("R9 top address", d, 32'h0);
    rda(8'h02, d); check("R9 unaligned", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_a2b;
    t_w1c;
    t_b2a;
    t_owner;
    t_collide;
    t_unmapped;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 20000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule